// File: doc/BRIEF.md
# Sequenced Trigger and Qualified Sample Capture

This block sits behind a set of match units in an on-chip logic analyser. Each cycle it receives one flag per match unit and walks through a programmable chain of sequencer levels. Every level waits for the match flag that its select field names. When the chain reaches the programmed last level, the block declares the trigger. If the sequencer is removed at build time (zero levels), the trigger becomes a direct function of the flags: any flag enabled by a mask fires it.

While armed, the block writes probe samples into a circular sample memory. When storage qualification is built in, a sample is written only on cycles where the qualifier input is high. At the trigger it latches the write address, so the trigger sample can be placed within the stored window. It then stores a programmed number of further qualified samples, stops, and raises `done_o`. A one-cycle trigger-out pulse marks the trigger for logic elsewhere. Probe bits are split into groups, and each group has a build-time store switch. A stored word can then be fetched through a synchronous readback port.

Top module: `trig_capture`

## Requirements
- R1: After reset the block is idle: `trig_o`, `done_o`, `level_o` and `trig_addr_o` are 0, and no match flag has an effect until `arm_i` is pulsed.
- R2: A cycle with `arm_i` high restarts capture from any state: in the next cycle the level is 0, `done_o` is 0, and the write pointer is 0.
- R3: In the sequenced build, level k advances only when `match_i` bit number `sel_i[k*SEL_W +: SEL_W]` is high (SEL_W = clog2 of the flag count). The level advances at most one step per cycle, so two flags seen in the same cycle advance it once.
- R4: When the flag of level `final_lvl_i-1` is seen, the trigger is declared. In the next cycle `trig_o` is high for exactly one cycle and `level_o` equals `final_lvl_i`.
- R5: In the zero-level build, `sel_i` is a flag-enable mask. The trigger fires in the first armed cycle in which `match_i & sel_i` is non-zero, and flags outside the mask have no effect.
- R6: Before the trigger, each written sample goes to the write pointer, which then increments modulo DEPTH, so older samples are overwritten.
- R7: With qualification built in, cycles with `qual_i` low neither write nor advance the pointer. Without it, every armed cycle writes, whatever `qual_i` is.
- R8: After the trigger, exactly `post_len_i` more written samples are stored and then `done_o` rises. With `post_len_i` = 0, `done_o` rises together with `trig_o`.
- R9: `trig_addr_o` holds the write-pointer value of the trigger cycle. This is the address of the trigger sample when that cycle is qualified.
- R10: Bits `g*GROUP_W +: GROUP_W` of a stored word hold probe group g when bit g of STORE_MASK is set, and are zero otherwise.
- R11: `rd_data_o` returns the word at `rd_addr_i` one cycle later. Once `done_o` is high, no further sample is written and `trig_addr_o` stays fixed until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Restart capture and sequencer |
| match_i | input | NUM_FLAGS | Match flags from the match units |
| qual_i | input | 1 | Storage-qualification condition |
| probe_i | input | NUM_GROUPS*GROUP_W | Probe data to sample |
| sel_i | input | NUM_LEVELS*SEL_W, or NUM_FLAGS with zero levels | Per-level flag select, or the flag mask |
| final_lvl_i | input | clog2(max(NUM_LEVELS,1)+1) | Level at which the trigger is declared |
| post_len_i | input | clog2(DEPTH) | Number of samples stored after the trigger |
| rd_addr_i | input | clog2(DEPTH) | Readback address |
| trig_o | output | 1 | One-cycle trigger-out pulse |
| done_o | output | 1 | Capture finished |
| level_o | output | clog2(max(NUM_LEVELS,1)+1) | Current sequencer level |
| trig_addr_o | output | clog2(DEPTH) | Write address latched at the trigger |
| rd_data_o | output | NUM_GROUPS*GROUP_W | Readback word |

## Verification
Every result is due exactly one clock after the inputs that cause it. Level steps, the trigger pulse, `done_o`, the latched trigger address and each memory write all land on the next edge, and readback data for an address appears one edge after that address is applied. Inputs change on the falling edge. A behavioural model then advances one step from those inputs, and the next falling edge compares all outputs with the model, so each check samples one full register stage after its cause. The zero-level build is exercised by a short directed sequence whose expected values are counted out the same way.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [1:0] {
      CAP_IDLE,
      CAP_PRE,
      CAP_POST,
      CAP_DONE
   } cap_state_t;

   function automatic int sel_w(int flags);
      return (flags > 1) ? $clog2(flags) : 1;
   endfunction

   function automatic int sel_port_w(int levels, int flags);
      return (levels > 0) ? levels * sel_w(flags) : flags;
   endfunction

   function automatic int lvl_w(int levels);
      return $clog2(((levels > 0) ? levels : 1) + 1);
   endfunction

   function automatic bit is_pow2(longint v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tcap_seq.sv
module tcap_seq
   import tcap_pkg::*;
#(
   parameter int NUM_FLAGS  = 4,
   parameter int NUM_LEVELS = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        clear_i,
   input  logic                                        run_i,
   input  logic [NUM_FLAGS-1:0]                        match_i,
   input  logic [sel_port_w(NUM_LEVELS, NUM_FLAGS)-1:0] sel_i,
   input  logic [lvl_w(NUM_LEVELS)-1:0]                 final_i,
   output logic                                        fire_o,
   output logic [lvl_w(NUM_LEVELS)-1:0]                 level_o
);

   localparam int SEL_W = sel_w(NUM_FLAGS);
   localparam int LVL_W = lvl_w(NUM_LEVELS);

   logic             hit;
   logic             adv;
   logic [LVL_W-1:0] lvl_next;
   logic [LVL_W-1:0] level_q;

   if (NUM_LEVELS > 0) begin : g_chain
      logic [SEL_W-1:0] sel_a [NUM_LEVELS];
      logic [LVL_W:0]   nxt;

      for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_split
         assign sel_a[k] = sel_i[k*SEL_W +: SEL_W];
      end

      always_comb begin
         hit = 1'b0;
         for (int k = 0; k < NUM_LEVELS; k++) begin
            if (level_q == LVL_W'(k)) hit = match_i[sel_a[k]];
         end
      end

      assign nxt      = {1'b0, level_q} + 1'b1;
      assign adv      = run_i && hit;
      assign fire_o   = adv && (nxt == {1'b0, final_i});
      assign lvl_next = nxt[LVL_W-1:0];
   end else begin : g_direct
      assign hit      = |(match_i & sel_i);
      assign adv      = run_i && hit;
      assign fire_o   = adv;
      assign lvl_next = final_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) level_q <= '0;
      else if (adv)          level_q <= lvl_next;
   end

   assign level_o = level_q;

   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1));

   // R4
   fire_at_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (level_q == $past(final_i)));

endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
   parameter int                  DEPTH      = 512,
   parameter int                  GROUP_W    = 4,
   parameter int                  NUM_GROUPS = 3,
   parameter logic [NUM_GROUPS-1:0] STORE_MASK = '1
) (
   input  logic                          clk,
   input  logic                          we_i,
   input  logic [$clog2(DEPTH)-1:0]      waddr_i,
   input  logic [NUM_GROUPS*GROUP_W-1:0] wdata_i,
   input  logic [$clog2(DEPTH)-1:0]      raddr_i,
   output logic [NUM_GROUPS*GROUP_W-1:0] rdata_o
);

   localparam int PROBE_W = NUM_GROUPS * GROUP_W;

   logic [PROBE_W-1:0] mem_q [DEPTH];
   logic [PROBE_W-1:0] kept;
   logic [PROBE_W-1:0] rdata_q;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (STORE_MASK[g]) begin : g_keep
         assign kept[g*GROUP_W +: GROUP_W] = wdata_i[g*GROUP_W +: GROUP_W];
      end else begin : g_drop
         assign kept[g*GROUP_W +: GROUP_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (we_i) mem_q[waddr_i] <= kept;
      rdata_q <= mem_q[raddr_i];
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/trig_capture.sv
module trig_capture
   import tcap_pkg::*;
#(
   parameter int                    NUM_FLAGS   = 4,
   parameter int                    NUM_LEVELS  = 4,
   parameter int                    DEPTH       = 512,
   parameter int                    GROUP_W     = 4,
   parameter int                    NUM_GROUPS  = 3,
   parameter logic [NUM_GROUPS-1:0] STORE_MASK  = '1,
   parameter bit                    QUAL_EN     = 1'b1,
   parameter bit                    TRIG_OUT_EN = 1'b1
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        arm_i,
   input  logic [NUM_FLAGS-1:0]                        match_i,
   input  logic                                        qual_i,
   input  logic [NUM_GROUPS*GROUP_W-1:0]               probe_i,
   input  logic [sel_port_w(NUM_LEVELS, NUM_FLAGS)-1:0] sel_i,
   input  logic [lvl_w(NUM_LEVELS)-1:0]                 final_lvl_i,
   input  logic [$clog2(DEPTH)-1:0]                    post_len_i,
   input  logic [$clog2(DEPTH)-1:0]                    rd_addr_i,
   output logic                                        trig_o,
   output logic                                        done_o,
   output logic [lvl_w(NUM_LEVELS)-1:0]                 level_o,
   output logic [$clog2(DEPTH)-1:0]                    trig_addr_o,
   output logic [NUM_GROUPS*GROUP_W-1:0]               rd_data_o
);

   localparam int AW = $clog2(DEPTH);

   if (!is_pow2(DEPTH) || DEPTH < 512 || DEPTH > 131072) begin : g_bad_depth
      $error("trig_capture: DEPTH must be a power of two from 512 to 131072");
   end
   if (NUM_LEVELS < 0 || NUM_LEVELS > 16) begin : g_bad_levels
      $error("trig_capture: NUM_LEVELS must lie in 0..16");
   end
   if (STORE_MASK == '0) begin : g_bad_mask
      $error("trig_capture: at least one probe group must be stored");
   end
   if (NUM_FLAGS < 1 || GROUP_W < 1 || NUM_GROUPS < 1) begin : g_bad_width
      $error("trig_capture: flag and probe widths must be positive");
   end

   cap_state_t    state_q;
   logic [AW-1:0] wr_ptr_q;
   logic [AW-1:0] trig_addr_q;
   logic [AW-1:0] rem_q;
   logic          trig_q;
   logic          fire;
   logic          run;
   logic          mem_we;

   assign run    = (state_q == CAP_PRE) && !arm_i;
   assign mem_we = !arm_i && ((state_q == CAP_PRE) || (state_q == CAP_POST))
                   && (qual_i || !QUAL_EN);

   tcap_seq #(
      .NUM_FLAGS  (NUM_FLAGS),
      .NUM_LEVELS (NUM_LEVELS)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (arm_i),
      .run_i   (run),
      .match_i (match_i),
      .sel_i   (sel_i),
      .final_i (final_lvl_i),
      .fire_o  (fire),
      .level_o (level_o)
   );

   tcap_store #(
      .DEPTH      (DEPTH),
      .GROUP_W    (GROUP_W),
      .NUM_GROUPS (NUM_GROUPS),
      .STORE_MASK (STORE_MASK)
   ) u_store (
      .clk     (clk),
      .we_i    (mem_we),
      .waddr_i (wr_ptr_q),
      .wdata_i (probe_i),
      .raddr_i (rd_addr_i),
      .rdata_o (rd_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= CAP_IDLE;
         wr_ptr_q    <= '0;
         trig_addr_q <= '0;
         rem_q       <= '0;
         trig_q      <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         if (arm_i) begin
            state_q  <= CAP_PRE;
            wr_ptr_q <= '0;
            rem_q    <= '0;
         end else begin
            if (mem_we) wr_ptr_q <= wr_ptr_q + 1'b1;
            unique case (state_q)
               CAP_PRE: begin
                  if (fire) begin
                     trig_addr_q <= wr_ptr_q;
                     trig_q      <= 1'b1;
                     rem_q       <= post_len_i;
                     state_q     <= (post_len_i == '0) ? CAP_DONE : CAP_POST;
                  end
               end
               CAP_POST: begin
                  if (mem_we) begin
                     rem_q <= rem_q - 1'b1;
                     if (rem_q == AW'(1)) state_q <= CAP_DONE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   if (TRIG_OUT_EN) begin : g_trig_out
      assign trig_o = trig_q;
   end else begin : g_no_trig_out
      assign trig_o = 1'b0;
   end

   assign done_o      = (state_q == CAP_DONE);
   assign trig_addr_o = trig_addr_q;

   // R4
   trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   // R7
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (QUAL_EN && !qual_i && !arm_i) |=> $stable(wr_ptr_q));

   // R11
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o && $stable(wr_ptr_q) && $stable(trig_addr_o));

   // R2
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !done_o && (wr_ptr_q == '0) && (level_o == '0));

endmodule

// File: tb/test_trig_capture.sv
`timescale 1ns/1ps
module test_trig_capture;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, arm, qual;
   logic [3:0]  match;
   logic [11:0] probe;
   logic [7:0]  sel;
   logic [2:0]  fin;
   logic [8:0]  post, raddr;
   logic        trig, done;
   logic [2:0]  lvl;
   logic [8:0]  taddr;
   logic [11:0] rdata;

   logic        d_arm, d_qual;
   logic [3:0]  d_match, d_sel;
   logic [11:0] d_probe;
   logic [0:0]  d_fin, d_lvl;
   logic [8:0]  d_post, d_raddr, d_taddr;
   logic        d_trig, d_done;
   logic [11:0] d_rdata;

   trig_capture #(
      .NUM_FLAGS(4), .NUM_LEVELS(4), .DEPTH(512), .GROUP_W(4), .NUM_GROUPS(3),
      .STORE_MASK(3'b101), .QUAL_EN(1'b1), .TRIG_OUT_EN(1'b1)
   ) i_trig_capture (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .match_i(match), .qual_i(qual),
      .probe_i(probe), .sel_i(sel), .final_lvl_i(fin), .post_len_i(post),
      .rd_addr_i(raddr), .trig_o(trig), .done_o(done), .level_o(lvl),
      .trig_addr_o(taddr), .rd_data_o(rdata)
   );

   trig_capture #(
      .NUM_FLAGS(4), .NUM_LEVELS(0), .DEPTH(512), .GROUP_W(4), .NUM_GROUPS(3),
      .STORE_MASK(3'b111), .QUAL_EN(1'b0), .TRIG_OUT_EN(1'b1)
   ) i_trig_capture_direct (
      .clk(clk), .rst_n(rst_n), .arm_i(d_arm), .match_i(d_match), .qual_i(d_qual),
      .probe_i(d_probe), .sel_i(d_sel), .final_lvl_i(d_fin), .post_len_i(d_post),
      .rd_addr_i(d_raddr), .trig_o(d_trig), .done_o(d_done), .level_o(d_lvl),
      .trig_addr_o(d_taddr), .rd_data_o(d_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   int          m_st, m_lvl, m_ptr, m_taddr, m_rem;
   bit          m_trig;
   logic [11:0] m_mem [512];
   logic [11:0] m_rd;
   bit          rd_chk;
   string       tag;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R10: group g kept when mask bit g is set; mask 101 keeps bits 11:8 and 3:0
   function automatic logic [11:0] keep(logic [11:0] p);
      return p & 12'hF0F;
   endfunction

   function void model_step();
      m_rd   = m_mem[raddr];
      m_trig = 1'b0;
      if (!rst_n) begin
         m_st = 0; m_lvl = 0; m_ptr = 0; m_taddr = 0; m_rem = 0;
      end else if (arm) begin
         m_st = 1; m_lvl = 0; m_ptr = 0; m_rem = 0;
      end else if (m_st == 1) begin
         if (match[sel[m_lvl*2 +: 2]]) begin
            if (m_lvl + 1 == int'(fin)) begin
               m_trig  = 1'b1;
               m_taddr = m_ptr;
               m_lvl   = int'(fin);
               m_rem   = int'(post);
               m_st    = (post == 0) ? 3 : 2;
            end else begin
               m_lvl++;
            end
         end
         if (qual) begin
            m_mem[m_ptr] = keep(probe);
            m_ptr = (m_ptr + 1) % 512;
         end
      end else if (m_st == 2 && qual) begin
         m_mem[m_ptr] = keep(probe);
         m_ptr = (m_ptr + 1) % 512;
         m_rem--;
         if (m_rem == 0) m_st = 3;
      end
   endfunction

   task automatic cyc();
      model_step();
      @(negedge clk);
      chk(tag, "trig_o", int'(trig), int'(m_trig));
      chk(tag, "done_o", int'(done), int'(m_st == 3));
      chk(tag, "level_o", int'(lvl), m_lvl);
      chk(tag, "trig_addr_o", int'(taddr), m_taddr);
      if (rd_chk) chk({tag, " R11 readback"}, "rd_data_o", int'(rdata), int'(m_rd));
   endtask

   task automatic drive(logic [3:0] m, logic q, logic [11:0] p);
      match = m; qual = q; probe = p;
      cyc();
   endtask

   task automatic arm_pulse();
      arm = 1'b1; match = '0; qual = 1'b0;
      cyc();
      arm = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) m_mem[i] = '0;
      rst_n = 1'b0; arm = 1'b0; match = '0; qual = 1'b0; probe = '0;
      sel = 8'b11_00_10_01; fin = 3'd3; post = 9'd5; raddr = '0;
      d_arm = 1'b0; d_qual = 1'b0; d_match = '0; d_sel = 4'b0100;
      d_probe = '0; d_fin = 1'b1; d_post = '0; d_raddr = '0;
      rd_chk = 1'b0;

      // R1: reset state, then flags ignored while unarmed
      tag = "R1";
      cyc(); cyc();
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) drive(4'hF, 1'b1, 12'h0AA);

      // R2: arm from idle
      tag = "R2";
      arm_pulse();

      // R3: ordered chain, level 0 waits for flag 1 only
      tag = "R3";
      drive(4'b0100, 1'b1, 12'h111);
      drive(4'b0110, 1'b1, 12'h122);
      tag = "R7";
      drive(4'b0000, 1'b0, 12'h222);
      tag = "R3";
      drive(4'b0100, 1'b1, 12'h333);
      tag = "R6";
      for (int i = 0; i < 6; i++) drive(4'b0000, (i % 2) == 0, 12'h400 + 12'(i));
      // R4 and R9: final step on flag 0
      tag = "R9 R4";
      drive(4'b0001, 1'b1, 12'hABC);
      tag = "R8";
      for (int i = 0; i < 10; i++) drive(4'hF, (i % 2) == 0, 12'h500 + 12'(i));
      tag = "R11";
      for (int i = 0; i < 5; i++) drive(4'hF, 1'b1, 12'h7FF);

      // R10: readback of the stored window with masked groups
      tag = "R10";
      match = '0; qual = 1'b0;
      rd_chk = 1'b1;
      for (int a = 0; a < 12; a++) begin
         raddr = 9'(a);
         cyc();
      end
      rd_chk = 1'b0;

      // R6: wrap-around, then R8 with zero post length
      tag = "R6";
      sel = 8'b00_00_00_11; fin = 3'd1; post = 9'd0;
      arm_pulse();
      for (int i = 0; i < 600; i++) drive(4'b0000, 1'b1, 12'(i));
      tag = "R8";
      drive(4'b1000, 1'b1, 12'hFFF);
      tag = "R4";
      drive(4'b0000, 1'b1, 12'h000);
      tag = "R6";
      match = '0; qual = 1'b0;
      rd_chk = 1'b1;
      for (int a = 0; a < 512; a++) begin
         raddr = 9'(a);
         cyc();
      end
      rd_chk = 1'b0;

      // R2: arm during post-trigger capture
      tag = "R2";
      post = 9'd10;
      arm_pulse();
      drive(4'b1000, 1'b1, 12'h001);
      drive(4'b0000, 1'b1, 12'h002);
      drive(4'b0000, 1'b1, 12'h003);
      arm_pulse();
      drive(4'b0000, 1'b1, 12'h004);
      drive(4'b1000, 1'b1, 12'h005);

      // R5 and R7: zero-level build, mask 0100, no qualification
      d_arm = 1'b1;
      @(negedge clk);
      d_arm = 1'b0; d_probe = 12'h0A1;
      @(negedge clk);
      d_probe = 12'h0B2; d_match = 4'b0010;
      @(negedge clk);
      chk("R5", "masked-out flag trig", int'(d_trig), 0);
      chk("R5", "masked-out flag level", int'(d_lvl), 0);
      d_match = '0; d_probe = 12'h0C3;
      @(negedge clk);
      d_probe = 12'h0D4; d_match = 4'b0100;
      @(negedge clk);
      chk("R5", "trig", int'(d_trig), 1);
      chk("R5", "done", int'(d_done), 1);
      chk("R5", "level", int'(d_lvl), 1);
      chk("R7", "trig addr", int'(d_taddr), 3);
      d_match = '0;
      @(negedge clk);
      chk("R5", "trig falls", int'(d_trig), 0);
      d_raddr = 9'd1;
      @(negedge clk);
      chk("R7", "unqualified write kept", int'(d_rdata), 12'h0B2);
      d_raddr = 9'd3;
      @(negedge clk);
      chk("R7", "trigger sample", int'(d_rdata), 12'h0D4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule